// File: doc/BRIEF.md
# RTC Alarm Match Comparator

This block watches the running calendar counters of a real-time clock and raises an alarm when they agree with a stored alarm time. Seven alarm bytes are held inside the block: hundredths, seconds, minutes, hour, date, month and weekday. A three-bit repeat code chooses which of them take part in the comparison. Coarser fields drop out, so the alarm can recur every second, minute, hour, day, week, month or year. Two special hundredths values, used with the once-per-second code, turn the alarm into a periodic alarm at tenths or hundredths of a second.

The comparison is made only on the cycle in which the counter block signals a hundredths tick. One match therefore produces exactly one set event. The alarm flag stays set until the host clears it. When enabled, an active-low interrupt output either follows the flag (level mode) or emits a fixed-length low pulse for each set event (pulse mode). The counters themselves live outside this block and arrive as BCD bytes.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the alarm flag is 0, the interrupt output is high, and all seven alarm bytes are 0.
- R2: A comparison happens only in a cycle with `tick` high. On a match the flag reads 1 from the next clock edge. Without `tick` the flag never sets.
- R3: The repeat code selects the compared fields. 7 compares hundredths only. 6 adds seconds. 5 adds minutes. 4 adds the hour. 3 compares hundredths, seconds, minutes, hour and weekday. 2 compares hundredths, seconds, minutes, hour and date. 1 compares hundredths, seconds, minutes, hour, date and month. 0 disables the alarm.
- R4: With repeat code 7 and an alarm hundredths byte whose upper nibble is 0xF (other than 0xFF), only the lower nibble of hundredths is compared. This gives one match per tenth of a second.
- R5: With repeat code 7 and an alarm hundredths byte of 0xFF, every tick is a match.
- R6: The hour byte is compared in full, including bit 5, which marks PM in 12-hour mode. An alarm differing from the counter only in bit 5 does not match.
- R7: The flag stays set until a cycle with `flagClr` high clears it. When a set event and a clear fall in the same cycle, the flag ends up set.
- R8: With `irqMode` = 0 (level), `irqN` is low exactly while the flag is set and `irqEn` is high.
- R9: With `irqMode` = 1, 2 or 3 (pulse), a set event taken while `irqEn` is high drives `irqN` low for `irqMode` × PULSE_UNIT clock cycles, starting at the edge that sets the flag. After the pulse `irqN` returns high even though the flag remains set. A set event with `irqEn` low produces no pulse.
- R10: A write with `almWrEn` high stores `almWrData` into the alarm byte chosen by `almWrSel`: 0 hundredths, 1 seconds, 2 minutes, 3 hour, 4 date, 5 month, 6 weekday.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe when the hundredths counter advances |
| curHund | input | 8 | Live hundredths (BCD) |
| curSec | input | 8 | Live seconds (BCD) |
| curMin | input | 8 | Live minutes (BCD) |
| curHour | input | 8 | Live hour (BCD, bit 5 = PM in 12-hour mode) |
| curDate | input | 8 | Live day of month (BCD) |
| curMonth | input | 8 | Live month (BCD) |
| curWday | input | 8 | Live weekday |
| almWrEn | input | 1 | Alarm byte write strobe |
| almWrSel | input | 3 | Alarm byte select, 0..6 |
| almWrData | input | 8 | Alarm byte write data |
| repeatCode | input | 3 | Repeat code, 0 = off |
| irqMode | input | 2 | 0 = level, 1..3 = pulse length multiplier |
| irqEn | input | 1 | Interrupt output enable |
| flagClr | input | 1 | Host clear of the alarm flag |
| almFlag | output | 1 | Alarm status flag |
| irqN | output | 1 | Active-low interrupt output |

## Verification
The hardest condition to reach from the ports is a near miss. The live time must agree with the alarm in every compared field except one, which must differ by a single bit. A compared field that differs at random almost never lands there. The stimulus therefore copies the alarm bytes into the counters and flips one bit in one randomly chosen field, then compares the flag against a bench model for every repeat code. Directed cases cover the same-cycle set and clear, the PM bit, the tenths and hundredths periodic forms, and the length of the pulse.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    F_HUND  = 3'd0,
    F_SEC   = 3'd1,
    F_MIN   = 3'd2,
    F_HOUR  = 3'd3,
    F_DATE  = 3'd4,
    F_MONTH = 3'd5,
    F_WDAY  = 3'd6
  } fieldIdx_e;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic pulseOn;
  } almStrobes_t;

  // bit i set => field i takes part in the comparison
  function automatic logic [NUM_FIELDS-1:0] fieldMask(input logic [2:0] code);
    logic [NUM_FIELDS-1:0] m;
    case (code)
      3'd7:    m = 7'b000_0001;
      3'd6:    m = 7'b000_0011;
      3'd5:    m = 7'b000_0111;
      3'd4:    m = 7'b000_1111;
      3'd3:    m = 7'b100_1111;
      3'd2:    m = 7'b001_1111;
      3'd1:    m = 7'b011_1111;
      default: m = 7'b000_0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/rtc_alarm_datapath.sv
module rtc_alarm_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]    curFields,
  input  logic                                  wrEn,
  input  logic [SEL_W-1:0]                      wrSel,
  input  logic [FIELD_W-1:0]                    wrData,
  input  logic [2:0]                            repeatCode,
  input  logic [1:0]                            irqMode,
  input  logic                                  irqEn,
  input  almStrobes_t                           strobes,
  output logic                                  matchHit,
  output logic                                  almFlag,
  output logic                                  irqN
);
  localparam int NIB = 4;
  localparam logic [2:0] CODE_SECOND = 3'd7;

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] almReg;
  logic [NUM_FIELDS-1:0]              fieldEq;
  logic [NUM_FIELDS-1:0]              useMask;
  logic                               tenthsForm;
  logic                               everyTick;
  logic                               flagQ;

  // alarm byte storage, one register per field
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rst_n)
        almReg[g] <= '0;
      else if (wrEn && wrSel == SEL_W'(g))
        almReg[g] <= wrData;
    end
  end

  assign everyTick  = (repeatCode == CODE_SECOND) && (almReg[F_HUND] == '1);
  assign tenthsForm = (repeatCode == CODE_SECOND) &&
                      (almReg[F_HUND][FIELD_W-1 -: NIB] == '1) && !everyTick;

  // per-field equality; hundredths carries the periodic forms
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gCmp
    if (g == 0) begin : gHund
      always_comb begin
        if (everyTick)
          fieldEq[g] = 1'b1;
        else if (tenthsForm)
          fieldEq[g] = (almReg[g][NIB-1:0] == curFields[g][NIB-1:0]);
        else
          fieldEq[g] = (almReg[g] == curFields[g]);
      end
    end else begin : gPlain
      assign fieldEq[g] = (almReg[g] == curFields[g]);
    end
  end

  assign useMask  = fieldMask(repeatCode);
  assign matchHit = (repeatCode != 3'd0) && (&(fieldEq | ~useMask));

  // status flag: set dominates clear
  always_ff @(posedge clk) begin
    if (!rst_n)
      flagQ <= 1'b0;
    else if (strobes.setFlag)
      flagQ <= 1'b1;
    else if (strobes.clrFlag)
      flagQ <= 1'b0;
  end

  assign almFlag = flagQ;
  assign irqN    = (irqMode == 2'd0) ? !(flagQ && irqEn) : !strobes.pulseOn;
endmodule

// File: rtl/rtc_alarm_control.sv
module rtc_alarm_control
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_UNIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        matchHit,
  input  logic        flagClr,
  input  logic        irqEn,
  input  logic [1:0]  irqMode,
  output almStrobes_t strobes
);
  localparam int PULSE_MAX = 3 * PULSE_UNIT;
  localparam int CNT_W     = $clog2(PULSE_MAX + 1);

  logic             setEvent;
  logic             startPulse;
  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] pulseLen;

  assign setEvent   = tick && matchHit;
  assign startPulse = setEvent && irqEn && (irqMode != 2'd0);
  assign pulseLen   = CNT_W'(int'(irqMode) * PULSE_UNIT);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pulseCnt <= '0;
    else if (startPulse)
      pulseCnt <= pulseLen;
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - 1'b1;
  end

  assign strobes.setFlag = setEvent;
  assign strobes.clrFlag = flagClr;
  assign strobes.pulseOn = (pulseCnt != '0);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W    = 8,
  parameter int PULSE_UNIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [FIELD_W-1:0] curHund,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curMonth,
  input  logic [FIELD_W-1:0] curWday,
  input  logic               almWrEn,
  input  logic [SEL_W-1:0]   almWrSel,
  input  logic [FIELD_W-1:0] almWrData,
  input  logic [2:0]         repeatCode,
  input  logic [1:0]         irqMode,
  input  logic               irqEn,
  input  logic               flagClr,
  output logic               almFlag,
  output logic               irqN
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] curFields;
  almStrobes_t                        strobes;
  logic                               matchHit;

  assign curFields = {curWday, curMonth, curDate, curHour, curMin, curSec, curHund};

  rtc_alarm_control #(.PULSE_UNIT(PULSE_UNIT)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .matchHit (matchHit),
    .flagClr  (flagClr),
    .irqEn    (irqEn),
    .irqMode  (irqMode),
    .strobes  (strobes)
  );

  rtc_alarm_datapath #(.FIELD_W(FIELD_W)) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .curFields  (curFields),
    .wrEn       (almWrEn),
    .wrSel      (almWrSel),
    .wrData     (almWrData),
    .repeatCode (repeatCode),
    .irqMode    (irqMode),
    .irqEn      (irqEn),
    .strobes    (strobes),
    .matchHit   (matchHit),
    .almFlag    (almFlag),
    .irqN       (irqN)
  );
endmodule

// File: rtl/rtc_alarm_match_checker.sv
module rtc_alarm_match_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic [2:0] repeatCode,
  input logic [1:0] irqMode,
  input logic       irqEn,
  input logic       flagClr,
  input logic       almFlag,
  input logic       irqN
);
  // R2: the flag only rises one edge after a tick
  assert_flag_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(almFlag) |-> $past(tick));

  // R3: with the alarm disabled a clear flag stays clear
  assert_code_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (repeatCode == 3'd0 && !almFlag) |=> !almFlag);

  // R7: the flag only falls after a host clear
  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(almFlag) |-> $past(flagClr));

  // R8: level mode keeps the line high while no flag is pending
  assert_level_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqMode == 2'd0 && !almFlag) |-> irqN);

  // R9: in pulse mode the line only drops after a tick seen with enable
  assert_pulse_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irqN) && irqMode != 2'd0 && $stable(irqMode)) |-> ($past(tick) && $past(irqEn)));
endmodule

bind rtc_alarm_match rtc_alarm_match_checker uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .repeatCode (repeatCode),
  .irqMode    (irqMode),
  .irqEn      (irqEn),
  .flagClr    (flagClr),
  .almFlag    (almFlag),
  .irqN       (irqN)
);

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
  localparam int PULSE_UNIT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0][7:0] cur = '0;
  logic       almWrEn = 1'b0;
  logic [2:0] almWrSel = '0;
  logic [7:0] almWrData = '0;
  logic [2:0] repeatCode = '0;
  logic [1:0] irqMode = '0;
  logic       irqEn = 1'b0;
  logic       flagClr = 1'b0;
  logic       almFlag;
  logic       irqN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_match #(.FIELD_W(8), .PULSE_UNIT(PULSE_UNIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .curHund(cur[0]), .curSec(cur[1]), .curMin(cur[2]), .curHour(cur[3]),
    .curDate(cur[4]), .curMonth(cur[5]), .curWday(cur[6]),
    .almWrEn(almWrEn), .almWrSel(almWrSel), .almWrData(almWrData),
    .repeatCode(repeatCode), .irqMode(irqMode), .irqEn(irqEn),
    .flagClr(flagClr), .almFlag(almFlag), .irqN(irqN)
  );

  // independent model of the comparison rules
  function automatic bit expHit(input int code, input logic [6:0][7:0] a, input logic [6:0][7:0] c);
    bit h;
    bit base;
    if (code == 7 && a[0] == 8'hFF)           h = 1'b1;
    else if (code == 7 && a[0][7:4] == 4'hF)  h = (a[0][3:0] == c[0][3:0]);
    else                                       h = (a[0] == c[0]);
    base = h && a[1] == c[1] && a[2] == c[2] && a[3] == c[3];
    case (code)
      7: return h;
      6: return h && a[1] == c[1];
      5: return h && a[1] == c[1] && a[2] == c[2];
      4: return base;
      3: return base && a[6] == c[6];
      2: return base && a[4] == c[4];
      1: return base && a[4] == c[4] && a[5] == c[5];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeAlarm(input logic [6:0][7:0] a);
    for (int i = 0; i < 7; i++) begin
      almWrEn = 1'b1; almWrSel = 3'(i); almWrData = a[i];
      @(negedge clk);
    end
    almWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [6:0][7:0] a;
    logic [6:0][7:0] c;
    int n;
    void'($urandom(32'h5EED_1805));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state; alarm bytes zero -> hundredths 00 matches with code 7
    check(almFlag == 1'b0, "R1 flag", almFlag, 0);
    check(irqN == 1'b1, "R1 irqN", irqN, 1);
    repeatCode = 3'd7; cur = '0; cur[0] = 8'h00;
    pulseTick();
    check(almFlag == 1'b1, "R1 zero alarm bytes", almFlag, 1);
    clearFlag();

    // R2: match without tick never sets
    repeat (3) @(negedge clk);
    check(almFlag == 1'b0, "R2 no tick", almFlag, 0);

    // R3: code 0 disables
    repeatCode = 3'd0; pulseTick();
    check(almFlag == 1'b0, "R3 code off", almFlag, 0);

    // R3 R10: random near-miss trials across all codes
    for (int t = 0; t < 300; t++) begin
      int code;
      code = $urandom_range(1, 7);
      for (int i = 0; i < 7; i++) a[i] = 8'($urandom_range(0, 255));
      c = a;
      if ($urandom_range(0, 1) == 1) begin
        int k;
        k = $urandom_range(0, 6);
        c[k] = c[k] ^ (8'h01 << $urandom_range(0, 7));
      end
      writeAlarm(a);
      repeatCode = 3'(code); cur = c;
      clearFlag();
      pulseTick();
      check(almFlag == expHit(code, a, c), "R3 repeat mask random", almFlag, int'(expHit(code, a, c)));
    end

    // R4: tenths form
    a = '0; a[0] = 8'hF5; writeAlarm(a); repeatCode = 3'd7;
    cur[0] = 8'h75; clearFlag(); pulseTick();
    check(almFlag == 1'b1, "R4 tenths match", almFlag, 1);
    cur[0] = 8'hF4; clearFlag(); pulseTick();
    check(almFlag == 1'b0, "R4 tenths miss", almFlag, 0);

    // R5: every hundredth
    a[0] = 8'hFF; writeAlarm(a);
    cur[0] = 8'h38; clearFlag(); pulseTick();
    check(almFlag == 1'b1, "R5 every tick", almFlag, 1);

    // R6: PM bit on hour
    a = '0; a[3] = 8'h31; writeAlarm(a); repeatCode = 3'd4;
    cur = '0; cur[3] = 8'h11; clearFlag(); pulseTick();
    check(almFlag == 1'b0, "R6 PM mismatch", almFlag, 0);
    cur[3] = 8'h31; clearFlag(); pulseTick();
    check(almFlag == 1'b1, "R6 PM match", almFlag, 1);

    // R7: hold, set wins over clear
    repeat (4) @(negedge clk);
    check(almFlag == 1'b1, "R7 hold", almFlag, 1);
    tick = 1'b1; flagClr = 1'b1; @(negedge clk); tick = 1'b0; flagClr = 1'b0;
    check(almFlag == 1'b1, "R7 set beats clear", almFlag, 1);
    clearFlag();
    check(almFlag == 1'b0, "R7 clear", almFlag, 0);

    // R8: level mode
    irqMode = 2'd0; irqEn = 1'b0; pulseTick();
    check(irqN == 1'b1, "R8 disabled", irqN, 1);
    irqEn = 1'b1; #1;
    check(irqN == 1'b0, "R8 enabled", irqN, 0);
    @(negedge clk); clearFlag();
    check(irqN == 1'b1, "R8 cleared", irqN, 1);

    // R9: pulse length per mode
    for (int m = 1; m <= 3; m++) begin
      irqMode = 2'(m); irqEn = 1'b1; clearFlag();
      pulseTick();
      n = 0;
      while (irqN == 1'b0 && n < 100) begin n++; @(negedge clk); end
      check(n == m * PULSE_UNIT, "R9 pulse length", n, m * PULSE_UNIT);
      check(almFlag == 1'b1, "R9 flag after pulse", almFlag, 1);
    end
    irqMode = 2'd1; irqEn = 1'b0; clearFlag(); pulseTick();
    n = 0;
    for (int i = 0; i < 6; i++) begin if (irqN == 1'b0) n++; @(negedge clk); end
    check(n == 0, "R9 no pulse when disabled", n, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule